// File: doc/BRIEF.md
# Context-Tagged Associative TLB Lookup

The block searches a fully associative table of address translations for a 64-bit virtual address. Each entry has a tag made of the virtual page number and a 13-bit context, plus a translation word. The translation word holds a valid flag, a two-bit page-size code, a global flag, a privileged flag, a writable flag, a side-effect flag, a no-fault-only flag, a used flag and a physical frame number. Every entry compares under its own size mask, so 8 KB, 64 KB, 512 KB and 4 MB pages share one table. A global entry matches in any context.

Each request gives an address, a context selector, an access kind and the privilege of the requester. One cycle later the block returns a hit flag, a result code, a 41-bit physical frame address and read/write rights. The same edge updates three registers. The fault status register records the mode, the context type and a set of fault flags that can be set together. The fault address register holds the address that faulted. The tag access register holds the page address merged with the context, for the miss and fault handlers. Entries are loaded through a single write port; choosing which entry to replace is the job of the logic around the block.

Top module: `ctx_tlb_lookup`

## Requirements
- R1: After reset, rsp_valid, stat_reg, fault_addr and tag_access are all zero, and every entry is invalid, so any lookup misses.
- R2: An entry hits when its valid bit is set, its global bit is set or its context equals the selected context, and its page number equals the address under its size mask. req_ctx_sel encodes 0 = pri_ctx, 1 = sec_ctx, 2 or 3 = nucleus (context 0).
- R3: The entry data word is laid out as: bit0 valid, bits2:1 size code, bit3 global, bit4 privileged, bit5 writable, bit6 side-effect, bit7 no-fault-only, bit8 used, bits40:13 frame. Size code s excludes address bits 12+3s down to 13 from the compare, which gives 8 KB, 64 KB, 512 KB and 4 MB pages.
- R4: rsp_pa takes bits 40:13 from the entry frame where the size mask keeps bits, and from the request address where it excludes them. Bits 12:0 of rsp_pa are zero.
- R5: When several entries hit, the one with the lowest index supplies the translation.
- R6: A user request (req_priv=0) that hits a privileged entry gives result 2 (access fault) and sets status bit6.
- R7: A no-fault request (req_kind=2) sets status bit7 if the entry has the side-effect flag and status bit8 if it has the no-fault-only flag. Both bits may be set by the same request, and either one gives result 2. Other kinds ignore both flags.
- R8: A store (req_kind=1) to an entry that is not writable gives result 3 (protection), but only when no access fault applies. Result codes are 0 ok, 1 miss, 2 access fault, 3 protection.
- R9: On result 2 or 3, stat_reg is rewritten with bit0 valid=1, bit1 overwrite, bit2 = req_priv, bits4:3 = context type (0 primary, 1 secondary, 2 nucleus), bit5 store, and the fault flags of that request. The overwrite bit is set when the valid bit was already set.
- R10: A pulse on stat_clr zeroes stat_reg. When stat_clr coincides with a fault, the new fault is recorded with the overwrite bit clear.
- R11: On result 2 or 3, fault_addr loads req_va. On results 1, 2 or 3, tag_access loads req_va with bits 12:0 replaced by the selected context. A miss leaves stat_reg unchanged, and a clean hit leaves tag_access unchanged.
- R12: rsp_used returns the hit entry's used bit as it was before the request. A result-0 request sets that bit; a faulting request does not.
- R13: rsp_rights bit0 (read) is set only on result 0. Bit1 (write) is set on result 0 only when the entry is writable.
- R14: Each request cycle produces exactly one rsp_valid cycle, on the next clock edge. A lookup sees the table as it was before a write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_we | input | 1 | Write one table entry |
| ent_idx | input | 6 | Entry index for a write |
| ent_va | input | 64 | Virtual address tag for a write (bits 12:0 ignored) |
| ent_ctx | input | 13 | Context tag for a write |
| ent_data | input | 41 | Translation word for a write (layout in R3) |
| pri_ctx | input | 13 | Primary context value |
| sec_ctx | input | 13 | Secondary context value |
| stat_clr | input | 1 | Clear the fault status register |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Lookup virtual address |
| req_ctx_sel | input | 2 | Context selector |
| req_kind | input | 2 | 0 load, 1 store, 2 no-fault load, 3 load |
| req_priv | input | 1 | 1 = privileged requester |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | An entry matched |
| rsp_result | output | 2 | Result code |
| rsp_pa | output | 41 | Physical frame address |
| rsp_rights | output | 2 | bit0 read, bit1 write |
| rsp_used | output | 1 | Prior used bit of the matched entry |
| stat_reg | output | 9 | Fault status register |
| fault_addr | output | 64 | Fault address register |
| tag_access | output | 64 | Tag access register |

## Verification
Two events can land on the status register in the same cycle: a software clear and a new access or protection fault. The bench first leaves a fault recorded. It then raises stat_clr in the same cycle as a user lookup of a privileged entry, and expects the new syndrome with the overwrite bit clear. For contrast, it also issues back-to-back faults with no clear and expects the overwrite bit set. A second pairing is an accumulation within one request: a no-fault load of an entry that has both the side-effect and the no-fault-only flags must set both flag bits together.

// File: rtl/ctx_tlb_pkg.sv
package ctx_tlb_pkg;
    localparam int unsigned VA_W     = 64;
    localparam int unsigned PA_W     = 41;
    localparam int unsigned CTX_W    = 13;
    localparam int unsigned PG_SHIFT = 13;
    localparam int unsigned VPN_W    = VA_W - PG_SHIFT;
    localparam int unsigned PFN_W    = PA_W - PG_SHIFT;
    localparam int unsigned SZ_STEP  = 3;
    localparam int unsigned STAT_W   = 9;

    typedef enum logic [1:0] {
        CSEL_PRI = 2'd0, CSEL_SEC = 2'd1, CSEL_NUC = 2'd2, CSEL_NUC2 = 2'd3
    } ctx_sel_e;

    typedef enum logic [1:0] {
        ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_NOFAULT = 2'd2, ACC_LOAD2 = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        RES_OK = 2'd0, RES_MISS = 2'd1, RES_ACCESS = 2'd2, RES_PROT = 2'd3
    } res_e;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             used;
        logic             nfo;
        logic             side_eff;
        logic             writable;
        logic             priv;
        logic             global_m;
        logic [1:0]       size;
        logic             valid;
    } tte_t;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [CTX_W-1:0] ctx;
        tte_t             tte;
    } tlb_ent_t;

    // bit0 valid .. bit8 no-fault-only flag
    typedef struct packed {
        logic       nfo_flt;
        logic       se_flt;
        logic       priv_flt;
        logic       store;
        logic [1:0] ctx_type;
        logic       priv_mode;
        logic       overwrite;
        logic       valid;
    } stat_t;

    // 1 = page-number bit that takes part in the compare
    function automatic logic [VPN_W-1:0] vpn_keep_mask(input logic [1:0] sz);
        logic [VPN_W-1:0] low;
        low = (VPN_W'(1) << (SZ_STEP * sz)) - VPN_W'(1);
        return ~low;
    endfunction

    function automatic tte_t unpack_tte(input logic [PA_W-1:0] w);
        tte_t t;
        t.valid    = w[0];
        t.size     = w[2:1];
        t.global_m = w[3];
        t.priv     = w[4];
        t.writable = w[5];
        t.side_eff = w[6];
        t.nfo      = w[7];
        t.used     = w[8];
        t.pfn      = w[PA_W-1:PG_SHIFT];
        return t;
    endfunction
endpackage

// File: rtl/ctx_tlb_entry_array.sv
module ctx_tlb_entry_array
    import ctx_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IW = $clog2(ENTRIES)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IW-1:0]              wr_idx,
    input  tlb_ent_t                   wr_ent,
    input  logic                       touch_en,
    input  logic [IW-1:0]              touch_idx,
    output tlb_ent_t [ENTRIES-1:0]     ents
);
    tlb_ent_t [ENTRIES-1:0] ents_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ents_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_en && wr_idx == IW'(i)) begin
                    ents_q[i] <= wr_ent;
                end else if (touch_en && touch_idx == IW'(i)) begin
                    ents_q[i].tte.used <= 1'b1;
                end
            end
        end
    end

    assign ents = ents_q;

    // R12: a clean hit marks its entry as used
    a_r12_used_set: assert property (@(posedge clk) disable iff (rst)
        (touch_en && !(wr_en && wr_idx == touch_idx)) |=> ents_q[$past(touch_idx)].tte.used);
endmodule

// File: rtl/ctx_tlb_match.sv
module ctx_tlb_match
    import ctx_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IW = $clog2(ENTRIES)
) (
    input  tlb_ent_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]       vpn,
    input  logic [CTX_W-1:0]       ctx,
    output logic                   hit,
    output logic [IW-1:0]          hit_idx,
    output tte_t                   hit_tte,
    output logic [PFN_W-1:0]       hit_pfn
);
    logic [ENTRIES-1:0] match_vec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        logic [VPN_W-1:0] keep;
        logic             ctx_ok;
        assign keep         = vpn_keep_mask(ents[i].tte.size);
        assign ctx_ok       = ents[i].tte.global_m || (ents[i].ctx == ctx);
        assign match_vec[i] = ents[i].tte.valid && ctx_ok &&
                              (((ents[i].vpn ^ vpn) & keep) == '0);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_tte = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
                hit_tte = ents[i].tte;
            end
        end
    end

    logic [VPN_W-1:0] sel_keep;
    logic [PFN_W-1:0] pfn_keep;
    assign sel_keep = vpn_keep_mask(hit_tte.size);
    assign pfn_keep = sel_keep[PFN_W-1:0];
    assign hit_pfn  = (hit_tte.pfn & pfn_keep) | (vpn[PFN_W-1:0] & ~pfn_keep);
endmodule

// File: rtl/ctx_tlb_fault_unit.sv
module ctx_tlb_fault_unit
    import ctx_tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_fire,
    input  logic [VA_W-1:0]  va,
    input  logic [CTX_W-1:0] ctx,
    input  ctx_sel_e         ctx_sel,
    input  acc_kind_e        kind,
    input  logic             priv_mode,
    input  logic             hit,
    input  tte_t             tte,
    input  logic             stat_clr,
    output res_e             res,
    output stat_t            status_q,
    output logic [VA_W-1:0]  faddr_q,
    output logic [VA_W-1:0]  tag_q
);
    logic  is_store, is_nf, pv, se, nfo_f, acc_flt, prot, any_flt;
    stat_t new_stat;

    always_comb begin
        is_store = (kind == ACC_STORE);
        is_nf    = (kind == ACC_NOFAULT);
        pv       = hit && tte.priv && !priv_mode;
        se       = hit && is_nf && tte.side_eff;
        nfo_f    = hit && is_nf && tte.nfo;
        acc_flt  = pv || se || nfo_f;
        prot     = hit && !acc_flt && is_store && !tte.writable;
        if (!hit)         res = RES_MISS;
        else if (acc_flt) res = RES_ACCESS;
        else if (prot)    res = RES_PROT;
        else              res = RES_OK;
        any_flt = acc_flt || prot;

        new_stat           = '0;
        new_stat.valid     = 1'b1;
        new_stat.overwrite = status_q.valid && !stat_clr;
        new_stat.priv_mode = priv_mode;
        new_stat.ctx_type  = (ctx_sel == CSEL_PRI) ? 2'd0 :
                             (ctx_sel == CSEL_SEC) ? 2'd1 : 2'd2;
        new_stat.store     = is_store;
        new_stat.priv_flt  = pv;
        new_stat.se_flt    = se;
        new_stat.nfo_flt   = nfo_f;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            faddr_q  <= '0;
            tag_q    <= '0;
        end else begin
            if (req_fire && any_flt) begin
                status_q <= new_stat;
                faddr_q  <= va;
            end else if (stat_clr) begin
                status_q <= '0;
            end
            if (req_fire && res != RES_OK) begin
                tag_q <= {va[VA_W-1:PG_SHIFT], ctx};
            end
        end
    end

    // R9: a fault on a valid status leaves the overwrite bit set
    a_r9_overwrite: assert property (@(posedge clk) disable iff (rst)
        (req_fire && (res == RES_ACCESS || res == RES_PROT) && status_q.valid && !stat_clr)
        |=> (status_q.overwrite && status_q.valid));
    // R11: a miss does not touch the status register
    a_r11_miss_keeps_status: assert property (@(posedge clk) disable iff (rst)
        (req_fire && res == RES_MISS && !stat_clr) |=> $stable(status_q));
    // R11: tag access low bits carry the context after a miss or fault
    a_r11_tag_ctx: assert property (@(posedge clk) disable iff (rst)
        (req_fire && res != RES_OK) |=> (tag_q[PG_SHIFT-1:0] == $past(ctx)));
    // R10: a lone clear empties the status register
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !req_fire) |=> (status_q == '0));
endmodule

// File: rtl/ctx_tlb_lookup.sv
module ctx_tlb_lookup
    import ctx_tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ent_we,
    input  logic [IW-1:0]     ent_idx,
    input  logic [VA_W-1:0]   ent_va,
    input  logic [CTX_W-1:0]  ent_ctx,
    input  logic [PA_W-1:0]   ent_data,
    input  logic [CTX_W-1:0]  pri_ctx,
    input  logic [CTX_W-1:0]  sec_ctx,
    input  logic              stat_clr,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_ctx_sel,
    input  logic [1:0]        req_kind,
    input  logic              req_priv,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [1:0]        rsp_result,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [1:0]        rsp_rights,
    output logic              rsp_used,
    output logic [STAT_W-1:0] stat_reg,
    output logic [VA_W-1:0]   fault_addr,
    output logic [VA_W-1:0]   tag_access
);
    logic unused_lowbits;
    assign unused_lowbits = ^{ent_va[PG_SHIFT-1:0], ent_data[PG_SHIFT-1:9]};

    tlb_ent_t               wr_ent;
    tlb_ent_t [ENTRIES-1:0] ents;
    ctx_sel_e               csel;
    logic [CTX_W-1:0]       look_ctx;
    logic                   m_hit;
    logic [IW-1:0]          m_idx;
    tte_t                   m_tte;
    logic [PFN_W-1:0]       m_pfn;
    res_e                   res;
    stat_t                  status_q;

    assign wr_ent.vpn = ent_va[VA_W-1:PG_SHIFT];
    assign wr_ent.ctx = ent_ctx;
    assign wr_ent.tte = unpack_tte(ent_data);

    assign csel = ctx_sel_e'(req_ctx_sel);
    always_comb begin
        unique case (csel)
            CSEL_PRI: look_ctx = pri_ctx;
            CSEL_SEC: look_ctx = sec_ctx;
            default:  look_ctx = '0;
        endcase
    end

    ctx_tlb_entry_array #(.ENTRIES(ENTRIES)) arr_i (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (ent_we),
        .wr_idx    (ent_idx),
        .wr_ent    (wr_ent),
        .touch_en  (req_valid && res == RES_OK),
        .touch_idx (m_idx),
        .ents      (ents)
    );

    ctx_tlb_match #(.ENTRIES(ENTRIES)) match_i (
        .ents    (ents),
        .vpn     (req_va[VA_W-1:PG_SHIFT]),
        .ctx     (look_ctx),
        .hit     (m_hit),
        .hit_idx (m_idx),
        .hit_tte (m_tte),
        .hit_pfn (m_pfn)
    );

    ctx_tlb_fault_unit flt_i (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_valid),
        .va        (req_va),
        .ctx       (look_ctx),
        .ctx_sel   (csel),
        .kind      (acc_kind_e'(req_kind)),
        .priv_mode (req_priv),
        .hit       (m_hit),
        .tte       (m_tte),
        .stat_clr  (stat_clr),
        .res       (res),
        .status_q  (status_q),
        .faddr_q   (fault_addr),
        .tag_q     (tag_access)
    );

    assign stat_reg = status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_result <= 2'd0;
            rsp_pa     <= '0;
            rsp_rights <= 2'b00;
            rsp_used   <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            if (req_valid) begin
                rsp_hit    <= m_hit;
                rsp_result <= res;
                rsp_pa     <= m_hit ? {m_pfn, {PG_SHIFT{1'b0}}} : '0;
                rsp_rights <= (res == RES_OK) ? {m_tte.writable, 1'b1} : 2'b00;
                rsp_used   <= m_hit && m_tte.used;
            end
        end
    end

    // R14: one response per request, one edge later
    a_r14_latency: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r14_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R13: no rights unless the result is ok
    a_r13_no_rights_on_fault: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_result != 2'd0) |-> (rsp_rights == 2'b00));
    a_r13_write_implies_read: assert property (@(posedge clk) disable iff (rst)
        rsp_rights[1] |-> rsp_rights[0]);
    // R4: frame address low bits are always zero
    a_r4_pa_low_zero: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_pa[PG_SHIFT-1:0] == '0));
    // R8: protection result only on a store
    a_r8_prot_store: assert property (@(posedge clk) disable iff (rst)
        (req_valid && res == RES_PROT) |-> (req_kind == 2'd1));
endmodule

// File: tb/ctx_tlb_lookup_tb_top.sv
`timescale 1ns/1ps
module ctx_tlb_lookup_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        ent_we;
    logic [5:0]  ent_idx;
    logic [63:0] ent_va;
    logic [12:0] ent_ctx;
    logic [40:0] ent_data;
    logic [12:0] pri_ctx, sec_ctx;
    logic        stat_clr, req_valid, req_priv;
    logic [63:0] req_va;
    logic [1:0]  req_ctx_sel, req_kind;
    logic        rsp_valid, rsp_hit, rsp_used;
    logic [1:0]  rsp_result, rsp_rights;
    logic [40:0] rsp_pa;
    logic [8:0]  stat_reg;
    logic [63:0] fault_addr, tag_access;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ctx_tlb_lookup dut_i (
        .clk(clk), .rst(rst), .ent_we(ent_we), .ent_idx(ent_idx), .ent_va(ent_va),
        .ent_ctx(ent_ctx), .ent_data(ent_data), .pri_ctx(pri_ctx), .sec_ctx(sec_ctx),
        .stat_clr(stat_clr), .req_valid(req_valid), .req_va(req_va),
        .req_ctx_sel(req_ctx_sel), .req_kind(req_kind), .req_priv(req_priv),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_result(rsp_result),
        .rsp_pa(rsp_pa), .rsp_rights(rsp_rights), .rsp_used(rsp_used),
        .stat_reg(stat_reg), .fault_addr(fault_addr), .tag_access(tag_access)
    );

    localparam logic [12:0] PCTX = 13'h005;
    localparam logic [12:0] SCTX = 13'h0A7;

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [40:0] mk(input bit v, input logic [1:0] sz, input bit g,
            input bit pr, input bit w, input bit se, input bit nfo, input logic [27:0] pfn);
        return {pfn, 4'b0, 1'b0, nfo, se, w, pr, g, sz, v};
    endfunction

    function automatic logic [8:0] st(input bit ow, input bit pm, input logic [1:0] ct,
            input bit s, input bit pv, input bit se, input bit nfo);
        return {nfo, se, pv, s, ct, pm, ow, 1'b1};
    endfunction

    task automatic wr(input int idx, input logic [63:0] va, input logic [12:0] c, input logic [40:0] d);
        @(negedge clk);
        ent_we = 1; ent_idx = 6'(idx); ent_va = va; ent_ctx = c; ent_data = d;
        @(posedge clk);
        @(negedge clk);
        ent_we = 0;
    endtask

    task automatic look(input logic [63:0] va, input logic [1:0] sel, input logic [1:0] kind,
            input bit pr, input bit clr);
        @(negedge clk);
        req_valid = 1; req_va = va; req_ctx_sel = sel; req_kind = kind; req_priv = pr; stat_clr = clr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0; stat_clr = 0;
    endtask

    task automatic t_reset();
        chk("R1 rsp_valid", 64'(rsp_valid), 0);
        chk("R1 stat_reg", 64'(stat_reg), 0);
        chk("R1 fault_addr", fault_addr, 0);
        chk("R1 tag_access", tag_access, 0);
        look(64'h0000_0000_0000_0000, 2'd2, 2'd0, 1, 0);
        chk("R1 empty table misses", 64'(rsp_result), 1);
        chk("R14 rsp_valid after request", 64'(rsp_valid), 1);
    endtask

    task automatic t_basic();
        wr(0, 64'h0000_1234_5678_A000, PCTX, mk(1, 0, 0, 0, 0, 0, 0, 28'h0ABCDE1));
        look(64'h0000_1234_5678_A123, 2'd0, 2'd0, 1, 0);
        chk("R2 primary hit", 64'(rsp_hit), 1);
        chk("R4 pa 8K", 64'(rsp_pa), 64'({28'h0ABCDE1, 13'b0}));
        chk("R13 read only rights", 64'(rsp_rights), 1);
        chk("R12 used before", 64'(rsp_used), 0);
        look(64'h0000_1234_5678_A000, 2'd0, 2'd0, 1, 0);
        chk("R12 used after clean hit", 64'(rsp_used), 1);
        @(negedge clk);
        chk("R14 single response", 64'(rsp_valid), 0);
        look(64'h0000_1234_5678_A000, 2'd1, 2'd0, 1, 0);
        chk("R2 context mismatch misses", 64'(rsp_result), 1);
        chk("R11 tag access on miss", tag_access, {51'h0000_1234_5678_A000 >> 13, SCTX});
        chk("R11 miss leaves status", 64'(stat_reg), 0);
        chk("R13 no rights on miss", 64'(rsp_rights), 0);
    endtask

    task automatic t_global_nucleus();
        wr(1, 64'hFFFF_0000_0000_0000, 13'h1FFF, mk(1, 0, 1, 0, 0, 0, 0, 28'h0000001));
        look(64'hFFFF_0000_0000_0000, 2'd1, 2'd0, 1, 0);
        chk("R2 global ignores context", 64'(rsp_result), 0);
        wr(3, 64'h0000_0000_0020_0000, 13'h000, mk(1, 0, 0, 0, 0, 0, 0, 28'h0000033));
        look(64'h0000_0000_0020_0000, 2'd2, 2'd0, 1, 0);
        chk("R2 nucleus context zero", 64'(rsp_pa), 64'({28'h0000033, 13'b0}));
        look(64'h0000_0000_0020_0000, 2'd3, 2'd0, 1, 0);
        chk("R2 selector 3 is nucleus", 64'(rsp_result), 0);
        look(64'h0000_0000_0020_0000, 2'd0, 2'd0, 1, 0);
        chk("R2 primary misses ctx0 entry", 64'(rsp_result), 1);
    endtask

    task automatic t_sizes();
        logic [63:0] va;
        wr(2, 64'h0000_00AB_C040_0000, PCTX, mk(1, 3, 0, 0, 0, 0, 0, 28'h1234567));
        va = 64'h0000_00AB_C040_0000 + 64'h3F_E005;
        look(va, 2'd0, 2'd0, 1, 0);
        chk("R3 4M page hit", 64'(rsp_result), 0);
        chk("R4 4M pa merge", 64'(rsp_pa), 64'({(28'h1234567 & ~28'h1FF) | 28'(va[21:13]), 13'b0}));
        look(64'h0000_00AB_C080_0000, 2'd0, 2'd0, 1, 0);
        chk("R3 outside 4M page", 64'(rsp_result), 1);
        wr(4, 64'h0000_0000_7001_0000, PCTX, mk(1, 1, 0, 0, 0, 0, 0, 28'h00000F0));
        look(64'h0000_0000_7001_E000, 2'd0, 2'd0, 1, 0);
        chk("R4 64K pa merge", 64'(rsp_pa), 64'({28'h00000F7, 13'b0}));
        look(64'h0000_0000_7002_0000, 2'd0, 2'd0, 1, 0);
        chk("R3 outside 64K page", 64'(rsp_result), 1);
    endtask

    task automatic t_priority();
        wr(11, 64'h0000_0000_0900_0000, PCTX, mk(1, 0, 0, 0, 0, 0, 0, 28'h11));
        wr(10, 64'h0000_0000_0900_0000, PCTX, mk(1, 0, 0, 0, 0, 0, 0, 28'h10));
        look(64'h0000_0000_0900_0000, 2'd0, 2'd0, 1, 0);
        chk("R5 lowest index wins", 64'(rsp_pa), 64'({28'h10, 13'b0}));
        wr(10, 64'h0, 13'h0, 41'h0);
        look(64'h0000_0000_0900_0000, 2'd0, 2'd0, 1, 0);
        chk("R5 next entry after invalidate", 64'(rsp_pa), 64'({28'h11, 13'b0}));
    endtask

    task automatic t_faults();
        wr(20, 64'h0000_0000_0A00_0000, PCTX, mk(1, 0, 0, 1, 1, 0, 0, 28'h20));
        look(64'h0000_0000_0A00_0040, 2'd0, 2'd0, 0, 0);
        chk("R6 user on privileged", 64'(rsp_result), 2);
        chk("R6 status", 64'(stat_reg), 64'(st(0, 0, 0, 0, 1, 0, 0)));
        chk("R11 fault address", fault_addr, 64'h0000_0000_0A00_0040);
        chk("R11 tag access on fault", tag_access, {51'h0000_0000_0A00_0000 >> 13, PCTX});
        look(64'h0000_0000_0A00_0000, 2'd0, 2'd0, 0, 0);
        chk("R9 overwrite on second fault", 64'(stat_reg), 64'(st(1, 0, 0, 0, 1, 0, 0)));
        look(64'h0000_0000_0A00_0000, 2'd0, 2'd0, 1, 0);
        chk("R12 fault does not set used", 64'(rsp_used), 0);
        @(negedge clk);
        stat_clr = 1;
        @(negedge clk);
        stat_clr = 0;
        chk("R10 clear alone", 64'(stat_reg), 0);
        wr(21, 64'h0000_0000_0B00_0000, PCTX, mk(1, 0, 0, 0, 0, 1, 1, 28'h21));
        look(64'h0000_0000_0B00_0000, 2'd0, 2'd2, 1, 0);
        chk("R7 no-fault result", 64'(rsp_result), 2);
        chk("R7 both flags", 64'(stat_reg), 64'(st(0, 1, 0, 0, 0, 1, 1)));
        look(64'h0000_0000_0B00_0000, 2'd0, 2'd0, 1, 0);
        chk("R7 plain load ignores flags", 64'(rsp_result), 0);
        chk("R7 status untouched by clean hit", 64'(stat_reg), 64'(st(0, 1, 0, 0, 0, 1, 1)));
        look(64'h0000_0000_0A00_0000, 2'd0, 2'd0, 0, 1);
        chk("R10 clear with fault no overwrite", 64'(stat_reg), 64'(st(0, 0, 0, 0, 1, 0, 0)));
        look(64'h0000_0000_0B00_0000, 2'd0, 2'd1, 1, 0);
        chk("R8 protection", 64'(rsp_result), 3);
        chk("R8 status", 64'(stat_reg), 64'(st(1, 1, 0, 1, 0, 0, 0)));
        look(64'h0000_0000_0A00_0000, 2'd0, 2'd1, 0, 0);
        chk("R8 access fault outranks protection", 64'(rsp_result), 2);
        chk("R9 store user status", 64'(stat_reg), 64'(st(1, 0, 0, 1, 1, 0, 0)));
        wr(23, 64'h0000_0000_0D00_0000, 13'h0, mk(1, 0, 1, 1, 0, 0, 0, 28'h23));
        look(64'h0000_0000_0D00_0000, 2'd1, 2'd0, 0, 1);
        chk("R9 secondary context type", 64'(stat_reg), 64'(st(0, 0, 1, 0, 1, 0, 0)));
        look(64'h0000_0000_0D00_0000, 2'd2, 2'd0, 0, 1);
        chk("R9 nucleus context type", 64'(stat_reg), 64'(st(0, 0, 2, 0, 1, 0, 0)));
    endtask

    task automatic t_rights();
        logic [63:0] tag_before;
        wr(22, 64'h0000_0000_0C00_0000, PCTX, mk(1, 0, 0, 0, 1, 0, 0, 28'h22));
        tag_before = tag_access;
        look(64'h0000_0000_0C00_0000, 2'd0, 2'd1, 1, 0);
        chk("R13 writable store rights", 64'(rsp_rights), 3);
        chk("R11 clean hit keeps tag access", tag_access, tag_before);
        @(negedge clk);
        ent_we = 1; ent_idx = 6'd22; ent_va = 64'h0; ent_ctx = 0; ent_data = 41'h0;
        req_valid = 1; req_va = 64'h0000_0000_0C00_0000; req_ctx_sel = 0; req_kind = 0; req_priv = 1;
        @(posedge clk);
        @(negedge clk);
        ent_we = 0; req_valid = 0;
        chk("R14 lookup sees table before write", 64'(rsp_result), 0);
        look(64'h0000_0000_0C00_0000, 2'd0, 2'd0, 1, 0);
        chk("R14 write visible next cycle", 64'(rsp_result), 1);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1; ent_we = 0; ent_idx = 0; ent_va = 0; ent_ctx = 0; ent_data = 0;
        pri_ctx = PCTX; sec_ctx = SCTX; stat_clr = 0; req_valid = 0; req_va = 0;
        req_ctx_sel = 0; req_kind = 0; req_priv = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_global_nucleus();
        t_sizes();
        t_priority();
        t_faults();
        t_rights();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule